// File: doc/BRIEF.md
# Interrupt Route Register Window

This block is the bus-facing register front end of an interrupt routing controller that serves a parameterised number of input pins (24 by default). A bus master reaches everything through two word offsets. At offset 0x00 it writes an 8-bit select value. At offset 0x10 it reads or writes a 32-bit data window. The select value decides what the window shows: a 4-bit identification field, a read-only version word, or one 32-bit half of a pin's 64-bit routing entry.

Each routing entry holds the fields the delivery logic decodes: the vector, the delivery mode, the destination, the trigger mode, the mask and the remote-IRR status bit. The block emits a one-cycle strobe, with the pin number, when a bus write flips an entry's mask bit. It emits a one-cycle service request, with the pin number, when a write leaves a level-triggered entry whose request line is active. The delivery logic sets a pin's remote-IRR bit through a set input. Delivering the interrupt is not part of this block.

Top module: `irq_route_regs`

## Requirements
- R1: A write to offset 0x00 stores bits 7:0 of the write data as the select value. A read of offset 0x00 returns that value in bits 7:0, with zeros above.
- R2: With select 0x01, a window read returns (pin count - 1) in bits 23:16 and the version code in bits 7:0, with all other bits zero (0x00170011 by default). Window writes with this select change nothing.
- R3: With select 0x00, a window write stores data bits 27:24 as the identification field. A window read returns the field in bits 27:24 and zeros elsewhere.
- R4: For select values of 0x10 and above, the pin is (select - 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. Every written bit reads back unchanged, except bit 14 of the low half (remote-IRR), which is status. The entry layout is: vector in bits 7:0, trigger mode in bit 15 (1 = level) and mask in bit 16.
- R5: A window read whose select is 0x02 to 0x0F, or whose pin is at or past the pin count, returns all ones. A window write with such a select changes no state and raises no strobe.
- R6: A low-half write clears that entry's remote-IRR bit, whatever the data's bit 14. A pulse on remoteIrrSet[p] sets it. A high-half write leaves it unchanged.
- R7: After reset, every entry reads as low half 0x00010000 (only the mask set) and high half 0. The select value and the identification field read as zero.
- R8: A low-half write that changes the mask bit raises maskChg for exactly the next cycle, with maskChgPin set to the pin and maskChgVal set to the new mask. A write that leaves the mask unchanged raises no strobe.
- R9: A write to either half of an entry whose resulting trigger bit is 1 while pinReq of that pin is 1 raises serviceReq for the next cycle, with servicePin set to the pin. Otherwise no request is raised.
- R10: Reads of any offset other than 0x00 and 0x10 return zero. Writes to such offsets change nothing.
- R11: When a low-half write and a remoteIrrSet pulse hit the same pin in the same cycle, the write wins and the bit ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write enable for one cycle |
| busAddr | input | 8 | Byte offset inside the register window |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from busAddr and state |
| pinReq | input | NPINS | Request level of each pin, from the delivery logic |
| remoteIrrSet | input | NPINS | Sets the remote-IRR bit of each pin |
| maskChg | output | 1 | Strobe: a write changed an entry's mask |
| maskChgPin | output | PIN_W | Pin whose mask changed |
| maskChgVal | output | 1 | New mask value |
| serviceReq | output | 1 | Strobe: a level entry needs service |
| servicePin | output | PIN_W | Pin to service |

## Verification
The assertions assume that busAddr and busWrData are stable and known around each rising edge, and that a write lasts exactly one cycle. The bench drives every input on the falling edge and holds each write for a single cycle. The assertions also assume that pulses on remoteIrrSet come only from the delivery side. They never look at it to explain a strobe, so the bench may pulse it alongside a bus write without breaking a property. pinReq is held steady across each write, so the expected service request depends only on the level present at that write's edge.

// File: rtl/irq_win_pkg.sv
package irq_win_pkg;
  localparam int SEL_W  = 8;
  localparam int IDX_W  = SEL_W - 1;
  localparam int DATA_W = 32;

  localparam logic [SEL_W-1:0] OFF_SEL  = 8'h00;
  localparam logic [SEL_W-1:0] OFF_WIN  = 8'h10;
  localparam logic [SEL_W-1:0] SEL_ID   = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VER  = 8'h01;
  localparam logic [SEL_W-1:0] SEL_BASE = 8'h10;

  localparam int MASK_BIT = 16;
  localparam int TRIG_BIT = 15;
  localparam int RIRR_BIT = 14;
  localparam int ID_LSB   = 24;
  localparam int ID_W     = 4;

  typedef enum logic [2:0] {
    RK_ZERO, RK_SEL, RK_ID, RK_VER, RK_LO, RK_HI, RK_ONES
  } rdKind_e;

  typedef struct packed {
    logic             selWr;
    logic             idWr;
    logic             loWr;
    logic             hiWr;
    logic [IDX_W-1:0] pin;
    rdKind_e          rdKind;
  } winCtl_t;
endpackage

// File: rtl/irq_win_ctrl.sv
module irq_win_ctrl
  import irq_win_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic             busWrEn,
  input  logic [SEL_W-1:0] busAddr,
  input  logic [SEL_W-1:0] selReg,
  output winCtl_t          ctl
);
  logic             isEnt;
  logic             inRange;
  logic             winWr;
  logic [IDX_W-1:0] idx;
  rdKind_e          winKind;

  always_comb begin
    isEnt   = (selReg >= SEL_BASE);
    idx     = selReg[SEL_W-1:1] - IDX_W'(SEL_BASE >> 1);
    inRange = isEnt && (int'(idx) < NPINS);

    if (selReg == SEL_ID)       winKind = RK_ID;
    else if (selReg == SEL_VER) winKind = RK_VER;
    else if (!inRange)          winKind = RK_ONES;
    else if (selReg[0])         winKind = RK_HI;
    else                        winKind = RK_LO;

    winWr = busWrEn && (busAddr == OFF_WIN);

    ctl        = '0;
    ctl.pin    = idx;
    ctl.selWr  = busWrEn && (busAddr == OFF_SEL);
    ctl.idWr   = winWr && (selReg == SEL_ID);
    ctl.loWr   = winWr && inRange && !selReg[0];
    ctl.hiWr   = winWr && inRange && selReg[0];
    if (busAddr == OFF_SEL)      ctl.rdKind = RK_SEL;
    else if (busAddr == OFF_WIN) ctl.rdKind = winKind;
    else                         ctl.rdKind = RK_ZERO;
  end
endmodule

// File: rtl/irq_win_dp.sv
module irq_win_dp
  import irq_win_pkg::*;
#(
  parameter int          NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int         PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  winCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NPINS-1:0]  pinReq,
  input  logic [NPINS-1:0]  remoteIrrSet,
  output logic [SEL_W-1:0]  selReg,
  output logic [DATA_W-1:0] rdData,
  output logic              maskChg,
  output logic [PIN_W-1:0]  maskChgPin,
  output logic              maskChgVal,
  output logic              serviceReq,
  output logic [PIN_W-1:0]  servicePin
);
  localparam logic [DATA_W-1:0] LO_RESET = DATA_W'(1) << MASK_BIT;
  localparam logic [DATA_W-1:0] LO_KEEP  = ~(DATA_W'(1) << RIRR_BIT);
  localparam logic [DATA_W-1:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

  logic [DATA_W-1:0] entLo [NPINS];
  logic [DATA_W-1:0] entHi [NPINS];
  logic [NPINS-1:0]  remoteIrr;
  logic [ID_W-1:0]   idReg;

  logic [DATA_W-1:0] curLo;
  logic [DATA_W-1:0] curHi;
  logic              curRirr;
  logic              curReq;
  logic              newTrig;
  logic              entWr;

  // Selected entry, chosen by comparison so an out-of-range pin yields zeros.
  always_comb begin
    curLo   = '0;
    curHi   = '0;
    curRirr = 1'b0;
    curReq  = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (ctl.pin == IDX_W'(i)) begin
        curLo   = entLo[i];
        curHi   = entHi[i];
        curRirr = remoteIrr[i];
        curReq  = pinReq[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPINS; i++) begin
        entLo[i] <= LO_RESET;
        entHi[i] <= '0;
      end
      remoteIrr <= '0;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        if (ctl.loWr && ctl.pin == IDX_W'(i)) begin
          entLo[i]     <= wrData & LO_KEEP;
          remoteIrr[i] <= 1'b0;
        end else if (remoteIrrSet[i]) begin
          remoteIrr[i] <= 1'b1;
        end
        if (ctl.hiWr && ctl.pin == IDX_W'(i)) entHi[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= '0;
    end else begin
      if (ctl.selWr) selReg <= wrData[SEL_W-1:0];
      if (ctl.idWr)  idReg  <= wrData[ID_LSB +: ID_W];
    end
  end

  assign entWr   = ctl.loWr || ctl.hiWr;
  assign newTrig = ctl.loWr ? wrData[TRIG_BIT] : curLo[TRIG_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskChg    <= 1'b0;
      maskChgPin <= '0;
      maskChgVal <= 1'b0;
      serviceReq <= 1'b0;
      servicePin <= '0;
    end else begin
      maskChg    <= ctl.loWr && (wrData[MASK_BIT] != curLo[MASK_BIT]);
      maskChgPin <= ctl.pin[PIN_W-1:0];
      maskChgVal <= wrData[MASK_BIT];
      serviceReq <= entWr && newTrig && curReq;
      servicePin <= ctl.pin[PIN_W-1:0];
    end
  end

  always_comb begin
    case (ctl.rdKind)
      RK_SEL:  rdData = {{(DATA_W-SEL_W){1'b0}}, selReg};
      RK_ID:   rdData = DATA_W'(idReg) << ID_LSB;
      RK_VER:  rdData = VER_WORD;
      RK_LO:   rdData = curLo | (DATA_W'(curRirr) << RIRR_BIT);
      RK_HI:   rdData = curHi;
      RK_ONES: rdData = '1;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_win_pkg::*;
#(
  parameter int         NPINS   = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int        PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWrData,
  output logic [31:0]      busRdData,
  input  logic [NPINS-1:0] pinReq,
  input  logic [NPINS-1:0] remoteIrrSet,
  output logic             maskChg,
  output logic [PIN_W-1:0] maskChgPin,
  output logic             maskChgVal,
  output logic             serviceReq,
  output logic [PIN_W-1:0] servicePin
);
  winCtl_t          ctl;
  logic [SEL_W-1:0] selReg;

  irq_win_ctrl #(.NPINS(NPINS)) u_ctrl (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .selReg  (selReg),
    .ctl     (ctl)
  );

  irq_win_dp #(.NPINS(NPINS), .VERSION(VERSION)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .wrData       (busWrData),
    .pinReq       (pinReq),
    .remoteIrrSet (remoteIrrSet),
    .selReg       (selReg),
    .rdData       (busRdData),
    .maskChg      (maskChg),
    .maskChgPin   (maskChgPin),
    .maskChgVal   (maskChgVal),
    .serviceReq   (serviceReq),
    .servicePin   (servicePin)
  );
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int  NPINS = 24,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic [7:0]       busAddr,
  input logic [31:0]      busWrData,
  input logic [31:0]      busRdData,
  input logic             maskChg,
  input logic [PIN_W-1:0] maskChgPin,
  input logic             serviceReq,
  input logic [PIN_W-1:0] servicePin
);
  // R8
  mask_pin_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskChg |-> (int'(maskChgPin) < NPINS));

  // R8
  mask_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskChg |-> $past(busWrEn && busAddr == 8'h10));

  // R9
  service_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    serviceReq |-> ($past(busWrEn && busAddr == 8'h10) && int'(servicePin) < NPINS));

  // R10
  other_offset_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != 8'h00 && busAddr != 8'h10) |-> (busRdData == 32'h0));

  // R1
  sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h00) |-> (busRdData[31:8] == 24'h0));

  // R1
  sel_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWrEn && busAddr == 8'h00) && busAddr == 8'h00)
      |-> (busRdData[7:0] == $past(busWrData[7:0])));
endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .busRdData  (busRdData),
  .maskChg    (maskChg),
  .maskChgPin (maskChgPin),
  .serviceReq (serviceReq),
  .servicePin (servicePin)
);

// File: tb/irq_route_regs_bench.sv
`timescale 1ns/1ps
module irq_route_regs_bench;
  localparam int NP = 24;
  localparam logic [31:0] VER_EXP = 32'h0017_0011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic [NP-1:0] pinReq = '0;
  logic [NP-1:0] remoteIrrSet = '0;
  logic        maskChg, maskChgVal, serviceReq;
  logic [4:0]  maskChgPin, servicePin;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Bench model of the register state
  logic [31:0] mLo [NP];
  logic [31:0] mHi [NP];
  logic [NP-1:0] mRirr;
  logic [7:0]  mSel;
  logic [3:0]  mId;

  always #4 clk = ~clk;

  irq_route_regs u_irq_route_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinReq(pinReq),
    .remoteIrrSet(remoteIrrSet), .maskChg(maskChg), .maskChgPin(maskChgPin),
    .maskChgVal(maskChgVal), .serviceReq(serviceReq), .servicePin(servicePin)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expWin(input logic [7:0] s);
    int idx;
    if (s == 8'h00) return {4'h0, mId, 24'h0};
    if (s == 8'h01) return VER_EXP;
    if (s < 8'h10) return 32'hFFFF_FFFF;
    idx = (int'(s) - 16) >> 1;
    if (idx >= NP) return 32'hFFFF_FFFF;
    if (s[0]) return mHi[idx];
    return mLo[idx] | (32'(mRirr[idx]) << 14);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NP; i++) begin
      mLo[i] = 32'h0001_0000;
      mHi[i] = 32'h0;
    end
    mRirr = '0;
    mSel  = 8'h00;
    mId   = 4'h0;
  endtask

  // One-cycle bus write, optionally with a remote-IRR set pulse in the same cycle.
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic [NP-1:0] rset);
    logic expMc = 1'b0;
    logic expSv = 1'b0;
    logic trig;
    int idx = 0;
    mRirr = mRirr | rset;
    if (a == 8'h00) begin
      mSel = d[7:0];
    end else if (a == 8'h10) begin
      if (mSel == 8'h00) mId = d[27:24];
      else if (mSel >= 8'h10) begin
        idx = (int'(mSel) - 16) >> 1;
        if (idx < NP) begin
          if (!mSel[0]) begin
            expMc = (mLo[idx][16] != d[16]);
            mLo[idx] = d & ~32'h0000_4000;
            mRirr[idx] = 1'b0;
            trig = d[15];
          end else begin
            mHi[idx] = d;
            trig = mLo[idx][15];
          end
          expSv = trig && pinReq[idx];
        end
      end
    end
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1; remoteIrrSet = rset;
    @(negedge clk);
    busWrEn = 1'b0; remoteIrrSet = '0;
    check("R8 mask strobe", 32'(maskChg), 32'(expMc));
    if (expMc) begin
      check("R8 mask pin", 32'(maskChgPin), 32'(idx));
      check("R8 mask value", 32'(maskChgVal), 32'(d[16]));
    end
    check("R9 service strobe", 32'(serviceReq), 32'(expSv));
    if (expSv) check("R9 service pin", 32'(servicePin), 32'(idx));
  endtask

  task automatic readAt(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  // Walk every select value and compare the window against the model.
  task automatic sweepWindow(input string tag);
    for (int s = 0; s < 256; s++) begin
      busWrite(8'h00, 32'(s), '0);
      readAt(tag, 8'h10, expWin(8'(s)));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stimulus
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R7 reset state
    readAt("R7 select after reset", 8'h00, 32'h0);
    readAt("R7 id after reset", 8'h10, 32'h0);
    sweepWindow("R7 entries after reset");

    // R1 select keeps low byte
    busWrite(8'h00, 32'hABCD_12F5, '0);
    readAt("R1 select readback", 8'h00, 32'h0000_00F5);

    // R3 identification field
    busWrite(8'h00, 32'h0, '0);
    busWrite(8'h10, 32'hFFFF_FFFF, '0);
    readAt("R3 id all ones", 8'h10, 32'h0F00_0000);
    busWrite(8'h10, 32'h5A00_0000, '0);
    readAt("R3 id 0xA", 8'h10, 32'h0A00_0000);

    // R2 version word, writes ignored
    busWrite(8'h00, 32'h1, '0);
    readAt("R2 version", 8'h10, VER_EXP);
    busWrite(8'h10, 32'h1234_5678, '0);
    readAt("R2 version after write", 8'h10, VER_EXP);

    // R4 every entry, both halves, with a request pattern
    pinReq = 24'hA5_C3_96;
    for (int p = 0; p < NP; p++) begin
      busWrite(8'h00, 32'(16 + 2 * p), '0);
      busWrite(8'h10, 32'h9E37_79B9 * 32'(p + 1), '0);
      busWrite(8'h00, 32'(17 + 2 * p), '0);
      busWrite(8'h10, 32'h7F4A_7C15 * 32'(p + 3), '0);
    end
    sweepWindow("R4 entry readback");

    // R5 out-of-range writes change nothing
    for (int s = 2; s < 16; s++) begin
      busWrite(8'h00, 32'(s), '0);
      busWrite(8'h10, 32'hFFFF_FFFF, '0);
    end
    busWrite(8'h00, 32'h40, '0); busWrite(8'h10, 32'h0, '0);
    busWrite(8'h00, 32'h41, '0); busWrite(8'h10, 32'h0, '0);
    busWrite(8'h00, 32'hFF, '0); busWrite(8'h10, 32'h0, '0);
    sweepWindow("R5 state after ignored writes");

    // R6 remote-IRR set, kept by high write, cleared by low write
    busWrite(8'h04, 32'h0, {NP{1'b1}});
    busWrite(8'h00, 32'h16, '0);
    readAt("R6 remote bit set", 8'h10, expWin(8'h16));
    check("R6 remote bit visible", 32'(busRdData[14]), 32'h1);
    busWrite(8'h00, 32'h17, '0);
    busWrite(8'h10, 32'h0102_0304, '0);
    busWrite(8'h00, 32'h16, '0);
    readAt("R6 kept by high write", 8'h10, expWin(8'h16));
    check("R6 still set", 32'(busRdData[14]), 32'h1);
    busWrite(8'h10, 32'h0000_4022, '0);
    readAt("R6 cleared by low write", 8'h10, 32'h0000_0022);

    // R11 set and low write collide on pin 5
    busWrite(8'h00, 32'h1A, '0);
    busWrite(8'h10, 32'h0001_0041, 24'h00_0020);
    readAt("R11 write wins", 8'h10, 32'h0001_0041);

    // R8 mask toggles and a write that keeps the mask
    busWrite(8'h00, 32'h14, '0);
    busWrite(8'h10, 32'h0001_0010, '0);
    busWrite(8'h10, 32'h0000_0010, '0);
    busWrite(8'h10, 32'h0000_0011, '0);
    busWrite(8'h10, 32'h0001_0011, '0);

    // R9 level entry with and without request
    pinReq = 24'h00_0004;
    busWrite(8'h10, 32'h0000_8030, '0);
    busWrite(8'h00, 32'h15, '0);
    busWrite(8'h10, 32'hFF00_0000, '0);
    pinReq = '0;
    busWrite(8'h10, 32'hEE00_0000, '0);
    busWrite(8'h00, 32'h14, '0);
    busWrite(8'h10, 32'h0000_0031, '0);
    pinReq = 24'h00_0004;
    busWrite(8'h10, 32'h0000_0032, '0);

    // R10 other offsets
    busWrite(8'h04, 32'h0000_0099, '0);
    busWrite(8'h20, 32'h0F00_0000, '0);
    busWrite(8'hFF, 32'hFFFF_FFFF, '0);
    readAt("R10 offset 0x04 reads zero", 8'h04, 32'h0);
    readAt("R10 offset 0x20 reads zero", 8'h20, 32'h0);
    readAt("R10 select untouched", 8'h00, 32'h0000_0014);
    sweepWindow("R10 state untouched");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule